// File: doc/BRIEF.md
# Flash Command Interface Controller

This block is a synthesizable behavioural model of the command front end of an asynchronous NOR-style flash device. A host writes command bytes over a simple synchronous bus: `we` is held high for one clock with `addr` and `wdata`. The block decodes one-cycle and two-cycle command sequences and runs a simulated internal engine for byte program and block erase. Both operations take a parameterised number of clock cycles. A small on-chip byte array stands in for the cell array, and a register per block holds a lock bit. Reads are combinational on the same `addr` bus. `rdata` shows array contents, the status byte or identifier codes, depending on the selected read mode. Whenever the engine is busy, `rdata` shows the status byte.

An erase can be suspended so that the host can read, or program a byte in another block, before resuming it. A program can be suspended for reads, including a program started inside a suspended erase. Error flags in the status byte stay set until a clear-status command is written.

The control FSM (`fcic_cmd_fsm`) has these states and transitions:

- **ST_IDLE**
  - To ST_PROG_SETUP on 40h or 10h.
  - To ST_ERASE_SETUP on 20h.
  - To ST_LOCK_SETUP on 60h.
- **ST_PROG_SETUP**: the next write always leaves it.
  - To ST_PROG_BUSY when the target block is unlocked.
  - Otherwise back to ST_IDLE with a protect error.
- **ST_ERASE_SETUP**: the next write always leaves it.
  - To ST_ERASE_BUSY on D0h to an unlocked block.
  - To ST_IDLE with an error otherwise.
- **ST_LOCK_SETUP**: the next write returns to ST_IDLE.
- **ST_PROG_BUSY**
  - To ST_IDLE when the count ends.
  - To ST_PROG_SUSP on B0h.
- **ST_PROG_SUSP**: back to ST_PROG_BUSY on D0h.
- **ST_ERASE_BUSY**
  - To ST_IDLE when the count ends.
  - To ST_ERASE_SUSP on B0h.
- **ST_ERASE_SUSP**
  - To ST_ERASE_BUSY on D0h.
  - To ST_SP_SETUP on 40h or 10h.
- **ST_SP_SETUP**
  - To ST_SP_BUSY on a valid target.
  - Otherwise back to ST_ERASE_SUSP with an error.
- **ST_SP_BUSY**
  - To ST_ERASE_SUSP when the count ends.
  - To ST_SP_SUSP on B0h.
- **ST_SP_SUSP**: back to ST_SP_BUSY on D0h.

Top module: `fcic_top`

## Requirements
- R1: After reset, `ready` is 1, the read mode is array, and every array byte reads FFh. Writing FFh selects array reads, 70h selects status reads and 90h selects identifier reads. In identifier mode, `addr[1:0]` chooses what is read: 0 returns MFR_CODE, 1 returns DEV_CODE, 2 returns the lock bit of the addressed block in bit 0, and 3 returns 00h.
- R2: Writing 40h or 10h and then one more write (address, data) starts a program. `ready` goes low for exactly PROG_CYC cycles. The byte then holds its old value ANDed with the new data.
- R3: Writing 20h and then D0h starts an erase of the block given by the address of the D0h write. `ready` goes low for exactly ERASE_CYC cycles. Every byte of that block then reads FFh.
- R4: If the write after 20h is not D0h, nothing is erased and status bits 5 and 4 are both set (improper sequence).
- R5: The status byte is laid out as {7: ready, 6: erase suspended, 5: erase error, 4: program error, 3: always 0, 2: program suspended, 1: protect error, 0: always 0}. Bit 7 follows `ready`. While `ready` is 0, `rdata` returns the status byte whatever the read mode. Program setup, erase setup and suspend switch the read mode to status.
- R6: Writing 60h then 01h sets the lock bit of the addressed block; 60h then D0h clears all lock bits. A program to a locked block sets status bits 1 and 4. An erase of a locked block sets bits 1 and 5. In both cases the data is unchanged and `ready` stays 1.
- R7: B0h during an erase makes `ready` 1 and sets status bit 6, and erase progress halts. D0h resumes the erase, clears bit 6 and makes `ready` 0. The busy cycles before and after the suspend add up to ERASE_CYC counter steps.
- R8: B0h during a program sets status bit 2, makes `ready` 1 and allows array reads of the old data. D0h clears bit 2 and finishes the remaining PROG_CYC steps.
- R9: While an erase is suspended, only FFh, 70h, 90h, 50h, 40h/10h and D0h are acted on; other commands such as 60h and 20h are ignored. A program there completes and leaves the erase suspended. A program aimed at the suspended block is refused with status bits 5 and 4 set.
- R10: Status bits 5, 4 and 1 stay set until 50h is written. 50h clears only those bits.
- R11: Reset aborts any operation in progress, clears every flag and lock bit, returns the array to the erased state, and selects array reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| we | input | 1 | Bus write strobe, one cycle per write |
| addr | input | ADDR_W | Byte address for writes and reads; top BLK_W bits select the block |
| wdata | input | 8 | Command or program data |
| rdata | output | 8 | Read data for the current mode, or status while busy |
| ready | output | 1 | 1 when the internal engine is idle or suspended |

## Verification
The bench builds the block with ADDR_W=6, BLK_W=2, PROG_CYC=4 and ERASE_CYC=12. This gives four 16-byte blocks, so every block boundary, erase and lock case can be reached in a few hundred cycles. The short counts let the bench measure exact busy lengths, and suspend an erase part-way so that the remaining ERASE_CYC-5 steps can be checked after resume. It also runs a nested program inside a suspended erase, suspends a program, and resets in the middle of an erase.

// File: rtl/fcic_pkg.sv
package fcic_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_PROG_SETUP,
        ST_ERASE_SETUP,
        ST_LOCK_SETUP,
        ST_PROG_BUSY,
        ST_PROG_SUSP,
        ST_ERASE_BUSY,
        ST_ERASE_SUSP,
        ST_SP_SETUP,
        ST_SP_BUSY,
        ST_SP_SUSP
    } fsm_state_e;

    typedef enum logic [1:0] {
        RM_ARRAY,
        RM_STATUS,
        RM_IDENT
    } rd_mode_e;

    typedef struct packed {
        logic ess;   // erase suspended
        logic eerr;  // erase / sequence error
        logic perr;  // program error
        logic pss;   // program suspended
        logic dps;   // protect error
    } sr_flags_t;

    localparam logic [7:0] CMD_READ_ARRAY  = 8'hFF;
    localparam logic [7:0] CMD_READ_STATUS = 8'h70;
    localparam logic [7:0] CMD_READ_ID     = 8'h90;
    localparam logic [7:0] CMD_CLR_STATUS  = 8'h50;
    localparam logic [7:0] CMD_PROG        = 8'h40;
    localparam logic [7:0] CMD_PROG_ALT    = 8'h10;
    localparam logic [7:0] CMD_ERASE       = 8'h20;
    localparam logic [7:0] CMD_CONFIRM     = 8'hD0;
    localparam logic [7:0] CMD_SUSPEND     = 8'hB0;
    localparam logic [7:0] CMD_LOCK        = 8'h60;
    localparam logic [7:0] CMD_LOCK_SET    = 8'h01;

endpackage

// File: rtl/fcic_array.sv
module fcic_array #(
    parameter int ADDR_W = 8,
    parameter int BLK_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              prog_go,
    input  logic [ADDR_W-1:0] prog_addr,
    input  logic [7:0]        prog_data,
    input  logic              erase_go,
    input  logic [BLK_W-1:0]  erase_blk,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_q
);
    localparam int DEPTH = 1 << ADDR_W;
    localparam int OFS_W = ADDR_W - BLK_W;

    logic [7:0] word_q [DEPTH];

    for (genvar w = 0; w < DEPTH; w++) begin : g_word
        localparam logic [BLK_W-1:0]  WBLK  = BLK_W'(w >> OFS_W);
        localparam logic [ADDR_W-1:0] WADDR = ADDR_W'(w);
        logic [7:0] q;

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                q <= 8'hFF;
            end else if (erase_go && (erase_blk == WBLK)) begin
                q <= 8'hFF;
            end else if (prog_go && (prog_addr == WADDR)) begin
                q <= q & prog_data;
            end
        end

        assign word_q[w] = q;
    end

    assign rd_q = word_q[rd_addr];

endmodule

// File: rtl/fcic_lock_bank.sv
module fcic_lock_bank #(
    parameter int BLK_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             set_go,
    input  logic             clr_all,
    input  logic [BLK_W-1:0] blk,
    output logic             locked
);
    localparam int NBLK = 1 << BLK_W;

    logic [NBLK-1:0] lock_q;

    for (genvar b = 0; b < NBLK; b++) begin : g_blk
        localparam logic [BLK_W-1:0] BID = BLK_W'(b);
        always_ff @(posedge clk) begin
            if (!rst_n || clr_all) begin
                lock_q[b] <= 1'b0;
            end else if (set_go && (blk == BID)) begin
                lock_q[b] <= 1'b1;
            end
        end
    end

    assign locked = lock_q[blk];

endmodule

// File: rtl/fcic_cmd_fsm.sv
module fcic_cmd_fsm
    import fcic_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int BLK_W     = 3,
    parameter int PROG_CYC  = 8,
    parameter int ERASE_CYC = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    input  logic              blk_locked,
    output logic              ready,
    output logic [7:0]        status,
    output rd_mode_e          mode,
    output logic              prog_go,
    output logic [ADDR_W-1:0] prog_addr,
    output logic [7:0]        prog_data,
    output logic              erase_go,
    output logic [BLK_W-1:0]  erase_blk,
    output logic              lock_set,
    output logic              lock_clr
);
    localparam int MAX_CYC = (PROG_CYC > ERASE_CYC) ? PROG_CYC : ERASE_CYC;
    localparam int CNT_W   = $clog2(MAX_CYC + 1);
    localparam logic [CNT_W-1:0] P_LOAD = CNT_W'(PROG_CYC);
    localparam logic [CNT_W-1:0] E_LOAD = CNT_W'(ERASE_CYC);
    localparam logic [CNT_W-1:0] LAST   = CNT_W'(1);

    fsm_state_e        state, state_n;
    rd_mode_e          mode_n;
    sr_flags_t         flg, flg_n;
    logic [CNT_W-1:0]  pcnt, pcnt_n, ecnt, ecnt_n;
    logic [ADDR_W-1:0] pa, pa_n;
    logic [7:0]        pd, pd_n;
    logic [BLK_W-1:0]  eb, eb_n;
    logic [BLK_W-1:0]  wr_blk;
    logic              quiet;

    assign wr_blk = addr[ADDR_W-1 -: BLK_W];

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            mode  <= RM_ARRAY;
            flg   <= '0;
            pcnt  <= '0;
            ecnt  <= '0;
            pa    <= '0;
            pd    <= '0;
            eb    <= '0;
        end else begin
            state <= state_n;
            mode  <= mode_n;
            flg   <= flg_n;
            pcnt  <= pcnt_n;
            ecnt  <= ecnt_n;
            pa    <= pa_n;
            pd    <= pd_n;
            eb    <= eb_n;
        end
    end

    // next state
    always_comb begin
        state_n = state;
        mode_n  = mode;
        flg_n   = flg;
        pcnt_n  = pcnt;
        ecnt_n  = ecnt;
        pa_n    = pa;
        pd_n    = pd;
        eb_n    = eb;
        quiet   = (state == ST_IDLE) || (state == ST_PROG_SUSP) ||
                  (state == ST_ERASE_SUSP) || (state == ST_SP_SUSP);

        if (we && quiet) begin
            case (wdata)
                CMD_READ_ARRAY:  mode_n = RM_ARRAY;
                CMD_READ_STATUS: mode_n = RM_STATUS;
                CMD_READ_ID:     mode_n = RM_IDENT;
                CMD_CLR_STATUS: begin
                    flg_n.eerr = 1'b0;
                    flg_n.perr = 1'b0;
                    flg_n.dps  = 1'b0;
                end
                default: ;
            endcase
        end

        unique case (state)
            ST_IDLE: begin
                if (we) begin
                    case (wdata)
                        CMD_PROG, CMD_PROG_ALT: begin
                            state_n = ST_PROG_SETUP;
                            mode_n  = RM_STATUS;
                        end
                        CMD_ERASE: begin
                            state_n = ST_ERASE_SETUP;
                            mode_n  = RM_STATUS;
                        end
                        CMD_LOCK: begin
                            state_n = ST_LOCK_SETUP;
                            mode_n  = RM_STATUS;
                        end
                        default: ;
                    endcase
                end
            end
            ST_PROG_SETUP: begin
                if (we) begin
                    pa_n = addr;
                    pd_n = wdata;
                    if (blk_locked) begin
                        flg_n.dps  = 1'b1;
                        flg_n.perr = 1'b1;
                        state_n    = ST_IDLE;
                    end else begin
                        pcnt_n  = P_LOAD;
                        state_n = ST_PROG_BUSY;
                    end
                end
            end
            ST_ERASE_SETUP: begin
                if (we) begin
                    state_n = ST_IDLE;
                    if (wdata != CMD_CONFIRM) begin
                        flg_n.eerr = 1'b1;
                        flg_n.perr = 1'b1;
                    end else if (blk_locked) begin
                        flg_n.dps  = 1'b1;
                        flg_n.eerr = 1'b1;
                    end else begin
                        eb_n    = wr_blk;
                        ecnt_n  = E_LOAD;
                        state_n = ST_ERASE_BUSY;
                    end
                end
            end
            ST_LOCK_SETUP: begin
                if (we) begin
                    state_n = ST_IDLE;
                    if ((wdata != CMD_LOCK_SET) && (wdata != CMD_CONFIRM)) begin
                        flg_n.eerr = 1'b1;
                        flg_n.perr = 1'b1;
                    end
                end
            end
            ST_PROG_BUSY, ST_SP_BUSY: begin
                if (pcnt == LAST) begin
                    state_n = (state == ST_SP_BUSY) ? ST_ERASE_SUSP : ST_IDLE;
                end else if (we && (wdata == CMD_SUSPEND)) begin
                    flg_n.pss = 1'b1;
                    mode_n    = RM_STATUS;
                    state_n   = (state == ST_SP_BUSY) ? ST_SP_SUSP : ST_PROG_SUSP;
                end else begin
                    pcnt_n = pcnt - LAST;
                end
            end
            ST_PROG_SUSP, ST_SP_SUSP: begin
                if (we && (wdata == CMD_CONFIRM)) begin
                    flg_n.pss = 1'b0;
                    state_n   = (state == ST_SP_SUSP) ? ST_SP_BUSY : ST_PROG_BUSY;
                end
            end
            ST_ERASE_BUSY: begin
                if (ecnt == LAST) begin
                    state_n = ST_IDLE;
                end else if (we && (wdata == CMD_SUSPEND)) begin
                    flg_n.ess = 1'b1;
                    mode_n    = RM_STATUS;
                    state_n   = ST_ERASE_SUSP;
                end else begin
                    ecnt_n = ecnt - LAST;
                end
            end
            ST_ERASE_SUSP: begin
                if (we) begin
                    case (wdata)
                        CMD_CONFIRM: begin
                            flg_n.ess = 1'b0;
                            state_n   = ST_ERASE_BUSY;
                        end
                        CMD_PROG, CMD_PROG_ALT: begin
                            mode_n  = RM_STATUS;
                            state_n = ST_SP_SETUP;
                        end
                        default: ;
                    endcase
                end
            end
            ST_SP_SETUP: begin
                if (we) begin
                    pa_n = addr;
                    pd_n = wdata;
                    if (wr_blk == eb) begin
                        flg_n.eerr = 1'b1;
                        flg_n.perr = 1'b1;
                        state_n    = ST_ERASE_SUSP;
                    end else if (blk_locked) begin
                        flg_n.dps  = 1'b1;
                        flg_n.perr = 1'b1;
                        state_n    = ST_ERASE_SUSP;
                    end else begin
                        pcnt_n  = P_LOAD;
                        state_n = ST_SP_BUSY;
                    end
                end
            end
            default: state_n = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        ready     = !((state == ST_PROG_BUSY) || (state == ST_ERASE_BUSY) ||
                      (state == ST_SP_BUSY));
        prog_go   = ((state == ST_PROG_BUSY) || (state == ST_SP_BUSY)) && (pcnt == LAST);
        erase_go  = (state == ST_ERASE_BUSY) && (ecnt == LAST);
        lock_set  = (state == ST_LOCK_SETUP) && we && (wdata == CMD_LOCK_SET);
        lock_clr  = (state == ST_LOCK_SETUP) && we && (wdata == CMD_CONFIRM);
        prog_addr = pa;
        prog_data = pd;
        erase_blk = eb;
        status    = {ready, flg.ess, flg.eerr, flg.perr, 1'b0, flg.pss, flg.dps, 1'b0};
    end

endmodule

// File: rtl/fcic_top.sv
module fcic_top
    import fcic_pkg::*;
#(
    parameter int          ADDR_W    = 8,
    parameter int          BLK_W     = 3,
    parameter int          PROG_CYC  = 8,
    parameter int          ERASE_CYC = 64,
    parameter logic [7:0]  MFR_CODE  = 8'h5A,
    parameter logic [7:0]  DEV_CODE  = 8'hC3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata,
    output logic              ready
);
    rd_mode_e          mode;
    logic [7:0]        status_w;
    logic              prog_go, erase_go, lock_set, lock_clr, blk_locked;
    logic [ADDR_W-1:0] prog_addr;
    logic [7:0]        prog_data;
    logic [BLK_W-1:0]  erase_blk;
    logic [7:0]        array_q;
    logic [7:0]        ident_q;

    fcic_cmd_fsm #(
        .ADDR_W(ADDR_W), .BLK_W(BLK_W), .PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n), .we(we), .addr(addr), .wdata(wdata),
        .blk_locked(blk_locked), .ready(ready), .status(status_w), .mode(mode),
        .prog_go(prog_go), .prog_addr(prog_addr), .prog_data(prog_data),
        .erase_go(erase_go), .erase_blk(erase_blk),
        .lock_set(lock_set), .lock_clr(lock_clr)
    );

    fcic_array #(.ADDR_W(ADDR_W), .BLK_W(BLK_W)) u_array (
        .clk(clk), .rst_n(rst_n), .prog_go(prog_go), .prog_addr(prog_addr),
        .prog_data(prog_data), .erase_go(erase_go), .erase_blk(erase_blk),
        .rd_addr(addr), .rd_q(array_q)
    );

    fcic_lock_bank #(.BLK_W(BLK_W)) u_locks (
        .clk(clk), .rst_n(rst_n), .set_go(lock_set), .clr_all(lock_clr),
        .blk(addr[ADDR_W-1 -: BLK_W]), .locked(blk_locked)
    );

    always_comb begin
        unique case (addr[1:0])
            2'd0:    ident_q = MFR_CODE;
            2'd1:    ident_q = DEV_CODE;
            2'd2:    ident_q = {7'd0, blk_locked};
            default: ident_q = 8'h00;
        endcase
    end

    always_comb begin
        if (!ready) begin
            rdata = status_w;
        end else begin
            unique case (mode)
                RM_ARRAY:  rdata = array_q;
                RM_IDENT:  rdata = ident_q;
                default:   rdata = status_w;
            endcase
        end
    end

endmodule

// File: rtl/fcic_checker.sv
module fcic_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       we,
    input logic [7:0] wdata,
    input logic       ready,
    input logic [7:0] rdata,
    input logic [7:0] status,
    input logic       prog_go,
    input logic       erase_go
);
    AST_BUSY_SHOWS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        !ready |-> !rdata[7]); // R5
    AST_SINGLE_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({prog_go, erase_go})); // R2
    AST_COMMIT_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (prog_go || erase_go) |-> !ready); // R3
    AST_PERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(status[4]) |-> $past(we && (wdata == 8'h50))); // R10
    AST_EERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(status[5]) |-> $past(we && (wdata == 8'h50))); // R10
    AST_DPS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(status[1]) |-> $past(we && (wdata == 8'h50))); // R6
    AST_ESUSP_READY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status[6]) |-> ready); // R7
    AST_ERESUME_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(status[6]) |-> !ready); // R7
    AST_PRESUME_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(status[2]) |-> !ready); // R8
endmodule

bind fcic_top fcic_checker u_fcic_checker (
    .clk(clk), .rst_n(rst_n), .we(we), .wdata(wdata), .ready(ready),
    .rdata(rdata), .status(status_w), .prog_go(prog_go), .erase_go(erase_go)
);

// File: tb/fcic_top_bench.sv
`timescale 1ns/1ps
module fcic_top_bench;
    localparam int PCYC = 4;
    localparam int ECYC = 12;
    localparam logic [1:0] OP_RD = 2'd0, OP_WR = 2'd1, OP_ID = 2'd2;
    localparam int N = 35;
    // {op, addr, data-or-expected-or-cycles, requirement number}
    localparam logic [21:0] TBL [N] = '{
        {OP_RD, 8'h00, 8'hFF, 4'd1},  // R1 array after reset
        {OP_WR, 8'h00, 8'h70, 4'd1},  // R1
        {OP_RD, 8'h00, 8'h80, 4'd1},  // R1 status idle
        {OP_WR, 8'h00, 8'h90, 4'd1},  // R1
        {OP_RD, 8'h00, 8'h5A, 4'd1},  // R1 manufacturer
        {OP_RD, 8'h01, 8'hC3, 4'd1},  // R1 device
        {OP_RD, 8'h12, 8'h00, 4'd1},  // R1 lock bit blk1
        {OP_WR, 8'h00, 8'h40, 4'd2},  // R2
        {OP_WR, 8'h05, 8'h3C, 4'd2},  // R2
        {OP_RD, 8'h05, 8'h00, 4'd5},  // R5 busy read
        {OP_ID, 8'h00, 8'h04, 4'd2},  // R2
        {OP_RD, 8'h05, 8'h80, 4'd5},  // R5 status mode after program
        {OP_WR, 8'h00, 8'hFF, 4'd2},  // R2
        {OP_RD, 8'h05, 8'h3C, 4'd2},  // R2
        {OP_WR, 8'h00, 8'h10, 4'd2},  // R2 alternate opcode
        {OP_WR, 8'h05, 8'hF0, 4'd2},  // R2
        {OP_ID, 8'h00, 8'h04, 4'd2},  // R2
        {OP_WR, 8'h00, 8'hFF, 4'd2},  // R2
        {OP_RD, 8'h05, 8'h30, 4'd2},  // R2 AND
        {OP_WR, 8'h00, 8'h20, 4'd3},  // R3
        {OP_WR, 8'h00, 8'hD0, 4'd3},  // R3
        {OP_RD, 8'h07, 8'h00, 4'd5},  // R5
        {OP_ID, 8'h00, 8'h0C, 4'd3},  // R3
        {OP_RD, 8'h07, 8'h80, 4'd3},  // R3
        {OP_WR, 8'h00, 8'hFF, 4'd3},  // R3
        {OP_RD, 8'h05, 8'hFF, 4'd3},  // R3 erased
        {OP_WR, 8'h00, 8'h20, 4'd4},  // R4
        {OP_WR, 8'h05, 8'h30, 4'd4},  // R4 bad confirm
        {OP_RD, 8'h05, 8'hB0, 4'd4},  // R4
        {OP_WR, 8'h00, 8'hFF, 4'd10}, // R10
        {OP_RD, 8'h05, 8'hFF, 4'd4},  // R4 untouched
        {OP_WR, 8'h00, 8'h70, 4'd10}, // R10
        {OP_RD, 8'h00, 8'hB0, 4'd10}, // R10 sticky
        {OP_WR, 8'h00, 8'h50, 4'd10}, // R10
        {OP_RD, 8'h00, 8'h80, 4'd10}  // R10 cleared
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       we = 1'b0;
    logic [5:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       ready;
    int         total = 0;
    int         bad = 0;

    always #2 clk = ~clk;

    fcic_top #(.ADDR_W(6), .BLK_W(2), .PROG_CYC(PCYC), .ERASE_CYC(ECYC)) u_fcic_top (
        .clk(clk), .rst_n(rst_n), .we(we), .addr(addr), .wdata(wdata),
        .rdata(rdata), .ready(ready)
    );

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        we = 1'b1; addr = a[5:0]; wdata = d;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [7:0] exp, input string req);
        addr = a[5:0];
        #0.5;
        chk(req, int'(rdata), int'(exp));
    endtask

    task automatic busy_len(output int n);
        n = 0;
        while (!ready && n < 1000) begin
            @(negedge clk);
            n++;
        end
    endtask

    initial begin
        int n;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chk("R1 ready after reset", int'(ready), 1);

        for (int i = 0; i < N; i++) begin
            case (TBL[i][21:20])
                OP_WR: wr(TBL[i][19:12], TBL[i][11:4]);
                OP_ID: repeat (int'(TBL[i][11:4])) @(negedge clk);
                default: rd(TBL[i][19:12], TBL[i][11:4],
                            $sformatf("R%0d table step %0d", TBL[i][3:0], i));
            endcase
        end

        // R2 / R3 exact busy lengths
        wr(8'h00, 8'h40); wr(8'h25, 8'h0F);
        busy_len(n); chk("R2 program busy cycles", n, PCYC);
        wr(8'h00, 8'h20); wr(8'h30, 8'hD0);
        busy_len(n); chk("R3 erase busy cycles", n, ECYC);

        // R6 locking
        wr(8'h00, 8'h60); wr(8'h18, 8'h01);
        wr(8'h00, 8'h90); rd(8'h12, 8'h01, "R6 lock bit set");
        wr(8'h00, 8'h40); wr(8'h13, 8'h00);
        chk("R6 no busy on locked program", int'(ready), 1);
        rd(8'h13, 8'h92, "R6 program protect status");
        wr(8'h00, 8'hFF); rd(8'h13, 8'hFF, "R6 locked data unchanged");
        wr(8'h00, 8'h50);
        wr(8'h00, 8'h20); wr(8'h10, 8'hD0);
        rd(8'h10, 8'hA2, "R6 erase protect status");
        wr(8'h00, 8'h50);
        wr(8'h00, 8'h60); wr(8'h00, 8'hD0);
        wr(8'h00, 8'h90); rd(8'h12, 8'h00, "R6 locks cleared");

        // R7 / R9 erase suspend with nested program
        wr(8'h00, 8'h20); wr(8'h20, 8'hD0);
        repeat (5) @(negedge clk);
        wr(8'h00, 8'hB0);
        chk("R7 ready after suspend", int'(ready), 1);
        rd(8'h00, 8'hC0, "R7 suspend status");
        wr(8'h00, 8'hFF); rd(8'h25, 8'h0F, "R7 erase halted");
        wr(8'h00, 8'h40); wr(8'h03, 8'hAA);
        busy_len(n); chk("R9 program in suspend cycles", n, PCYC);
        rd(8'h00, 8'hC0, "R9 erase still suspended");
        wr(8'h00, 8'hFF); rd(8'h03, 8'hAA, "R9 program in suspend data");
        wr(8'h00, 8'h40); wr(8'h22, 8'h55);
        rd(8'h22, 8'hF0, "R9 same block refused");
        wr(8'h00, 8'h50); rd(8'h00, 8'hC0, "R10 clear keeps suspend flag");
        wr(8'h00, 8'h60); wr(8'h28, 8'h01);
        wr(8'h00, 8'h90); rd(8'h22, 8'h00, "R9 lock command ignored");
        wr(8'h00, 8'hD0);
        chk("R7 busy after resume", int'(ready), 0);
        busy_len(n); chk("R7 remaining erase cycles", n, ECYC - 5);
        wr(8'h00, 8'hFF); rd(8'h25, 8'hFF, "R7 erase completed");
        wr(8'h00, 8'h70); rd(8'h00, 8'h80, "R7 suspend flag cleared");

        // R8 program suspend
        wr(8'h00, 8'h40); wr(8'h31, 8'h3C); wr(8'h00, 8'hB0);
        rd(8'h00, 8'h84, "R8 program suspend status");
        wr(8'h00, 8'hFF); rd(8'h31, 8'hFF, "R8 old data readable");
        wr(8'h00, 8'hD0);
        busy_len(n); chk("R8 resumed program cycles", n, PCYC);
        wr(8'h00, 8'hFF); rd(8'h31, 8'h3C, "R8 program finished");

        // R11 reset mid-erase
        wr(8'h00, 8'h20); wr(8'h30, 8'hD0);
        repeat (3) @(negedge clk);
        rst_n = 1'b0; @(negedge clk); rst_n = 1'b1;
        chk("R11 ready after reset", int'(ready), 1);
        rd(8'h31, 8'hFF, "R11 array mode after reset");
        wr(8'h00, 8'h70); rd(8'h00, 8'h80, "R11 status clean");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule